// File: doc/BRIEF.md
# Stereo Attenuation and Channel Mixer

This block sits between the serial sample receiver and the interpolation filter of a stereo audio converter. Each accepted sample pair gets a per-channel linear gain, is steered or mixed onto the two outputs, and is silenced or forced to midscale according to control fields held in a register file. One cycle after an input strobe, the processed pair leaves with its own strobe. A flag travels with it that tells the analog stage to park at its midscale level.

The gain code is eight bits and represents code/256, except that the top code stands for unity. The gain actually applied does not jump to a new code. It walks one code per accepted sample toward the programmed value, so a change of gain is heard as a short linear slide. A shared-gain option lets the left code drive both channels. Each output has a two-bit selector that picks silence, the left channel, the right channel or the mean of the two.

Top module: `stereo_gain_mixer`

## Requirements
- R1: While reset is asserted and right after it, out_valid, out_left, out_right and out_mid are all 0.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. Without in_valid the output samples and out_mid hold their values.
- R3: For an effective code c, the factor f is c/256 for c in 0..254 and 256/256 for c = 255. A gained sample is floor(sample*f/256), which is an arithmetic right shift of the product by 8.
- R4: Each channel's effective code starts at 255 after reset. On every accepted sample it moves one step toward its target, including samples that are muted or forced. The sample is scaled with the code as it was before the step.
- R5: The left target is cfg_att_left. The right target is cfg_att_right when cfg_shared_gain is 0 and cfg_att_left when it is 1, in which case cfg_att_right has no effect.
- R6: cfg_route[1:0] picks the left output: 0 gives zero, 1 the gained left, 2 the gained right, 3 floor((gained left + gained right)/2).
- R7: cfg_route[3:2] picks the right output with the same encoding. The value 4'b1001 sends left to left and right to right.
- R8: When cfg_mute is 1 or mute_n is 0, both output samples are 0. out_mid is not affected by mute.
- R9: When cfg_ground is 1, out_mid is 1 and both output samples are 0, whatever the input data.
- R10: When cfg_zero_det is 1 and both input samples are 0, out_mid is 1 and both outputs are 0. When cfg_zero_det is 0, or either input is nonzero, a zero input yields out_mid 0 and passes through normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 18 | Left input sample, two's complement |
| in_right | input | 18 | Right input sample, two's complement |
| cfg_att_left | input | 8 | Left gain code |
| cfg_att_right | input | 8 | Right gain code |
| cfg_shared_gain | input | 1 | Left code controls both channels |
| cfg_route | input | 4 | Output selectors: [1:0] left output, [3:2] right output |
| cfg_mute | input | 1 | Register mute, active high |
| mute_n | input | 1 | Pin mute, active low |
| cfg_ground | input | 1 | Force midscale unconditionally |
| cfg_zero_det | input | 1 | Force midscale on an all-zero input pair |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 18 | Processed left sample |
| out_right | output | 18 | Processed right sample |
| out_mid | output | 1 | Request analog midscale |

## Verification
Two functions can fall in the same cycle: the gain slide, which advances on every accepted sample, and the silencing paths (mute and the two midscale forces), which act on that same sample. The bench drives muted and forced samples while a slide is still in progress. It also sends one sample that is muted, zero-detected and carries a routing change all at once. Every output is judged against a bench model that keeps stepping the effective codes through those samples. The first unmuted sample afterwards therefore shows whether the slide kept moving.

// File: rtl/smx_pkg.sv
package smx_pkg;
  typedef enum logic [1:0] {
    RT_SILENT = 2'd0,
    RT_LEFT   = 2'd1,
    RT_RIGHT  = 2'd2,
    RT_MEAN   = 2'd3
  } route_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/smx_gain_ramp.sv
module smx_gain_ramp #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [GW-1:0] target,
  output logic [GW-1:0] cur_code,
  output logic [GW:0]   factor
);
  localparam logic [GW-1:0] CODE_TOP = {GW{1'b1}};
  localparam logic [GW:0]   UNITY    = {1'b1, {GW{1'b0}}};

  logic step_up, step_dn;
  assign step_up = step_en && (cur_code < target);
  assign step_dn = step_en && (cur_code > target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_code <= CODE_TOP;
    else if (step_up) cur_code <= cur_code + 1'b1;
    else if (step_dn) cur_code <= cur_code - 1'b1;
  end

  assign factor = (cur_code == CODE_TOP) ? UNITY : {1'b0, cur_code};

  // R4
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cur_code));
  // R4
  ramp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cur_code != target) |=> (cur_code != $past(cur_code)));
  // R4
  ramp_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cur_code == target) |=> $stable(cur_code));
endmodule

// File: rtl/smx_route.sv
module smx_route
  import smx_pkg::*;
#(
  parameter int DW = 18
) (
  input  route_e               sel,
  input  logic signed [DW-1:0] gained_l,
  input  logic signed [DW-1:0] gained_r,
  output logic signed [DW-1:0] y
);
  function automatic logic signed [DW-1:0] mean2(
    input logic signed [DW-1:0] a,
    input logic signed [DW-1:0] b
  );
    logic signed [DW:0] sum;
    sum = DW'(a) + DW'(b);
    sum = {a[DW-1], a} + {b[DW-1], b};
    return DW'(sum >>> 1);
  endfunction

  always_comb begin
    unique case (sel)
      RT_SILENT: y = '0;
      RT_LEFT:   y = gained_l;
      RT_RIGHT:  y = gained_r;
      RT_MEAN:   y = mean2(gained_l, gained_r);
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/stereo_gain_mixer.sv
module stereo_gain_mixer
  import smx_pkg::*;
#(
  parameter int DW = 18,
  parameter int GW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic [GW-1:0]        cfg_att_left,
  input  logic [GW-1:0]        cfg_att_right,
  input  logic                 cfg_shared_gain,
  input  logic [3:0]           cfg_route,
  input  logic                 cfg_mute,
  input  logic                 mute_n,
  input  logic                 cfg_ground,
  input  logic                 cfg_zero_det,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right,
  output logic                 out_mid
);
  localparam int PW = DW + GW + 2;

  function automatic logic signed [DW-1:0] apply_gain(
    input logic signed [DW-1:0] s,
    input logic [GW:0]          f
  );
    logic signed [PW-1:0] p;
    p = PW'(s) * PW'($signed({1'b0, f}));
    return p[GW +: DW];
  endfunction

  logic [GW-1:0]        tgt    [NUM_CH];
  logic [GW-1:0]        code   [NUM_CH];
  logic [GW:0]          fac    [NUM_CH];
  logic signed [DW-1:0] raw    [NUM_CH];
  logic signed [DW-1:0] gained [NUM_CH];
  logic signed [DW-1:0] routed [NUM_CH];

  assign tgt[0] = cfg_att_left;
  assign tgt[1] = cfg_shared_gain ? cfg_att_left : cfg_att_right;
  assign raw[0] = in_left;
  assign raw[1] = in_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    smx_gain_ramp #(.GW(GW)) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (in_valid),
      .target   (tgt[c]),
      .cur_code (code[c]),
      .factor   (fac[c])
    );
    assign gained[c] = apply_gain(raw[c], fac[c]);
    smx_route #(.DW(DW)) u_route (
      .sel      (route_e'(cfg_route[2*c +: 2])),
      .gained_l (gained[0]),
      .gained_r (gained[1]),
      .y        (routed[c])
    );
  end

  logic zero_in, mid_now, mute_now, silence;
  assign zero_in  = (in_left == '0) && (in_right == '0);
  assign mid_now  = cfg_ground || (cfg_zero_det && zero_in);
  assign mute_now = cfg_mute || !mute_n;
  assign silence  = mid_now || mute_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      out_mid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= silence ? '0 : routed[0];
        out_right <= silence ? '0 : routed[1];
        out_mid   <= mid_now;
      end
    end
  end

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));
  // R8
  mute_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cfg_mute || !mute_n)) |=> (out_left == '0 && out_right == '0));
  // R9
  ground_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_ground) |=> out_mid);
  // R9
  mid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_mid |-> (out_left == '0 && out_right == '0));
endmodule

// File: tb/stereo_gain_mixer_tb.sv
module stereo_gain_mixer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int GW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_left = '0, in_right = '0;
  logic [GW-1:0] cfg_att_left = 8'd255, cfg_att_right = 8'd255;
  logic cfg_shared_gain = 1'b0;
  logic [3:0] cfg_route = 4'b1001;
  logic cfg_mute = 1'b0, mute_n = 1'b1, cfg_ground = 1'b0, cfg_zero_det = 1'b0;
  logic out_valid, out_mid;
  logic signed [DW-1:0] out_left, out_right;

  int n_checks = 0;
  int n_fail = 0;
  int m_code_l = 255;
  int m_code_r = 255;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_gain_mixer #(.DW(DW), .GW(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .cfg_att_left(cfg_att_left), .cfg_att_right(cfg_att_right),
    .cfg_shared_gain(cfg_shared_gain), .cfg_route(cfg_route),
    .cfg_mute(cfg_mute), .mute_n(mute_n), .cfg_ground(cfg_ground),
    .cfg_zero_det(cfg_zero_det), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .out_mid(out_mid)
  );

  task automatic check(input string req, input string what, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic longint gain_of(input int c);
    return (c == 255) ? 256 : c;
  endfunction

  function automatic longint scaled(input longint s, input int c);
    longint p, q;
    p = s * gain_of(c);
    q = p / 256;
    if (p < 0 && (p % 256) != 0) q = q - 1;
    return q;
  endfunction

  function automatic longint pick(input int sel, input longint a, input longint b);
    longint t, h;
    case (sel)
      1: return a;
      2: return b;
      3: begin
        t = a + b;
        h = t / 2;
        if (t < 0 && (t % 2) != 0) h = h - 1;
        return h;
      end
      default: return 0;
    endcase
  endfunction

  function automatic int step(input int cur, input int tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  // Send one pair, predict its result from the requirements, check it.
  task automatic send(input string req, input int l, input int r);
    longint gl, gr, el, er;
    bit mid, quiet;
    int tl, tr;
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = DW'(l);
    in_right = DW'(r);
    gl = scaled(l, m_code_l);
    gr = scaled(r, m_code_r);
    mid = cfg_ground || (cfg_zero_det && l == 0 && r == 0);
    quiet = mid || cfg_mute || !mute_n;
    el = quiet ? 0 : pick(int'(cfg_route[1:0]), gl, gr);
    er = quiet ? 0 : pick(int'(cfg_route[3:2]), gl, gr);
    tl = int'(cfg_att_left);
    tr = cfg_shared_gain ? int'(cfg_att_left) : int'(cfg_att_right);
    m_code_l = step(m_code_l, tl);
    m_code_r = step(m_code_r, tr);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "out_valid", out_valid, 1);
    check(req, "out_left", out_left, el);
    check(req, "out_right", out_right, er);
    check(req, "out_mid", out_mid, mid);
  endtask

  task automatic t_reset();
    check("R1", "out_valid", out_valid, 0);
    check("R1", "out_left", out_left, 0);
    check("R1", "out_right", out_right, 0);
    check("R1", "out_mid", out_mid, 0);
  endtask

  task automatic t_straight();
    // R7 straight routing at unity
    send("R7", 1000, -2000);
    send("R7", 131071, -131072);
    send("R3", -3, 7);
  endtask

  task automatic t_hold();
    // R2 outputs hold and strobe drops without input
    send("R2", 12345, -54321);
    repeat (3) @(negedge clk);
    check("R2", "out_valid idle", out_valid, 0);
    check("R2", "out_left held", out_left, 12345);
    check("R2", "out_right held", out_right, -54321);
  endtask

  task automatic t_ramp();
    // R4 one step per sample, first sample still at unity
    cfg_att_left = 8'd250;
    for (int i = 0; i < 4; i++) send("R4", 100000, 100000);
    check("R4", "left code after 4", m_code_l, 251);
    cfg_att_left = 8'd128;
    cfg_att_right = 8'd64;
    for (int i = 0; i < 200; i++) send("R4", 4096 + i, -4096 - i);
    // R3 settled half and quarter gain, with floor on odd negatives
    send("R3", -3, -5);
    send("R3", 1001, 131071);
    send("R3", -131072, 255);
  endtask

  task automatic t_shared();
    // R5 right target follows left code
    cfg_shared_gain = 1'b1;
    cfg_att_right = 8'd10;
    for (int i = 0; i < 70; i++) send("R5", 2000, 2000);
    check("R5", "right code shared", m_code_r, 128);
    send("R5", -777, 999);
    cfg_shared_gain = 1'b0;
    cfg_att_right = 8'd128;
  endtask

  task automatic t_routes();
    cfg_route = 4'b0110;
    send("R6", 3000, -5000);
    cfg_route = 4'b1111;
    send("R6", 5, -8);
    send("R7", -131072, -131072);
    cfg_route = 4'b0000;
    send("R6", 400, 500);
    cfg_route = 4'b1000;
    send("R7", 400, 500);
    cfg_route = 4'b1001;
  endtask

  task automatic t_mute();
    cfg_mute = 1'b1;
    send("R8", 9999, -9999);
    cfg_mute = 1'b0;
    mute_n = 1'b0;
    send("R8", -123, 456);
    mute_n = 1'b1;
    send("R8", -123, 456);
  endtask

  task automatic t_force();
    cfg_ground = 1'b1;
    send("R9", 50000, -50000);
    cfg_ground = 1'b0;
    cfg_zero_det = 1'b1;
    send("R10", 0, 0);
    send("R10", 0, 1);
    cfg_zero_det = 1'b0;
    send("R10", 0, 0);
  endtask

  task automatic t_overlap();
    // R4 slide continues while mute, zero detect and a route change coincide
    cfg_att_left = 8'd200;
    cfg_mute = 1'b1;
    cfg_zero_det = 1'b1;
    cfg_route = 4'b1110;
    send("R8", 0, 0);
    send("R4", 0, 0);
    cfg_mute = 1'b0;
    cfg_zero_det = 1'b0;
    send("R4", 8000, -8000);
    cfg_route = 4'b1001;
    send("R6", 8000, -8000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_straight();
    t_hold();
    t_ramp();
    t_shared();
    t_routes();
    t_mute();
    t_force();
    t_overlap();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule